// File: doc/BRIEF.md
# Triggered Hit Latency Buffer with Sector Fast-OR

This block sits behind the discriminators of a 128-channel tracking front-end that runs on the bunch clock. Every cycle it turns each channel's discriminator level into a single-clock hit pulse. A per-channel dead window keeps a noisy or ringing input from firing again straight away. The sector outputs present these hits at once as eight OR-reduced trigger lines.

In parallel, the full hit pattern of every cycle goes into a 256-deep circular store. When a level-1 accept arrives, the pattern from a programmable number of clocks earlier is fetched. It is tagged with an accept counter and the bunch counter, and queued in a 16-entry event queue. A valid/ready port drains that queue in arrival order. An accept that finds the queue full is discarded and raises a sticky overflow flag.

Top module: `trig_latency_buf`

## Requirements
- R1: `fastOr[s]` is high for one cycle when any of channels 16*s to 16*s+15 produced a hit. A discriminator rising edge driven between clock edges is visible on `fastOr` after the third following rising clock edge.
- R2: A low-to-high transition of a channel's synchronized level makes exactly one one-cycle hit. For holdOff+1 cycles after that hit, further rising edges on the same channel make no hit.
- R3: An accept sampled on clock edge k queues the hit pattern that was registered on edge k-L, where L is the effective latency. Bit i of `rdHits` is channel i.
- R4: The effective latency L is `latency` when it lies in 1..255. A value of 0 acts as 1, and any value above 255 acts as 255.
- R5: `rdEvt` is the number of accepts sampled since reset before this one, counting dropped accepts, modulo 4096. `rdBx` is the number of rising edges since reset release before the accept edge, modulo 4096.
- R6: If the queue is empty, `rdValid` rises after the edge following the accept edge. The head entry stays valid and unchanged until it is taken with `rdReady` high, and events leave in accept order.
- R7: The queue holds at most 16 events. An accept arriving while 16 are held or pending is dropped.
- R8: `overflow` goes high after a dropped accept and stays high until reset.
- R9: During reset, `fastOr`, `rdValid` and `overflow` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rstN | input | 1 | Asynchronous active-low reset |
| discIn | input | 128 | Raw discriminator levels, one per channel |
| holdOff | input | 2 | Retrigger dead window minus one, in clocks |
| latency | input | 9 | Trigger latency in clocks (clamped) |
| l1a | input | 1 | Level-1 accept, one per cycle |
| fastOr | output | 8 | Sector OR trigger lines |
| rdReady | input | 1 | Consumer ready for the queue head |
| rdValid | output | 1 | Queue head holds an event |
| rdHits | output | 128 | Hit pattern of the head event |
| rdEvt | output | 12 | Accept counter of the head event |
| rdBx | output | 12 | Bunch counter of the head event |
| overflow | output | 1 | Sticky dropped-accept flag |

## Verification
The bench keeps its own edge count and a model of the synchronizer and dead window. From these it derives when each result is due. A fast-OR pulse belongs to the hit registered on the edge just before it, which lies three edges after the input change. A queued event becomes visible one edge after its accept edge. It may be popped from the second edge after the accept onward. All outputs are compared at the falling edge. Expectations are therefore fixed by the edge that produced them, and queue-full decisions use the occupancy before the same edge's pop.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int RING_AW = 8;
  localparam int TAG_W   = 12;

  typedef struct packed {
    logic               capture;
    logic               push;
    logic               pop;
    logic [RING_AW-1:0] wrAddr;
    logic [RING_AW-1:0] rdAddr;
    logic [TAG_W-1:0]   evtTag;
    logic [TAG_W-1:0]   bxTag;
  } ctl_t;
endpackage

// File: rtl/trig_latency_ctl.sv
module trig_latency_ctl
  import tlb_pkg::*;
#(
  parameter int EVQ_DEPTH = 16,
  parameter int LAT_W     = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             l1a,
  input  logic [LAT_W-1:0] latency,
  input  logic             rdReady,
  input  logic             rdValid,
  output ctl_t             ctl,
  output logic             overflow
);
  localparam int RING_DEPTH = 1 << RING_AW;
  localparam int OCC_W      = $clog2(EVQ_DEPTH + 1);

  logic [RING_AW-1:0] wrPtr;
  logic [RING_AW-1:0] latEff;
  logic [TAG_W-1:0]   bxCnt, evtCnt, evtTagR, bxTagR;
  logic [OCC_W-1:0]   occ;
  logic               pushR, accept, pop;

  // clamp latency into 1..RING_DEPTH-1
  always_comb begin
    if (latency == '0)
      latEff = RING_AW'(1);
    else if (latency > LAT_W'(RING_DEPTH - 1))
      latEff = RING_AW'(RING_DEPTH - 1);
    else
      latEff = latency[RING_AW-1:0];
  end

  assign accept = l1a && (occ != OCC_W'(EVQ_DEPTH));
  assign pop    = rdValid && rdReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      bxCnt    <= '0;
      evtCnt   <= '0;
      evtTagR  <= '0;
      bxTagR   <= '0;
      occ      <= '0;
      pushR    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      wrPtr <= wrPtr + 1'b1;
      bxCnt <= bxCnt + 1'b1;
      pushR <= accept;
      occ   <= occ + OCC_W'(accept) - OCC_W'(pop);
      if (l1a) evtCnt <= evtCnt + 1'b1;
      if (accept) begin
        evtTagR <= evtCnt;
        bxTagR  <= bxCnt;
      end
      if (l1a && !accept) overflow <= 1'b1;
    end
  end

  always_comb begin
    ctl.capture = accept;
    ctl.push    = pushR;
    ctl.pop     = pop;
    ctl.wrAddr  = wrPtr;
    ctl.rdAddr  = wrPtr - latEff;
    ctl.evtTag  = evtTagR;
    ctl.bxTag   = bxTagR;
  end

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  p_bx_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (bxCnt == $past(bxCnt) + TAG_W'(1)));

  p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(EVQ_DEPTH));
endmodule

// File: rtl/trig_latency_dp.sv
module trig_latency_dp
  import tlb_pkg::*;
#(
  parameter int NUM_CH    = 128,
  parameter int SECT_W    = 16,
  parameter int EVQ_DEPTH = 16,
  parameter int HOLD_W    = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CH-1:0]            discIn,
  input  logic [HOLD_W-1:0]            holdOff,
  input  ctl_t                         ctl,
  output logic [NUM_CH/SECT_W-1:0]     fastOr,
  output logic                         rdValid,
  output logic [NUM_CH-1:0]            rdHits,
  output logic [TAG_W-1:0]             rdEvt,
  output logic [TAG_W-1:0]             rdBx
);
  localparam int RING_DEPTH = 1 << RING_AW;
  localparam int N_SECT     = NUM_CH / SECT_W;
  localparam int EVQ_AW     = $clog2(EVQ_DEPTH);
  localparam int DEAD_W     = HOLD_W + 1;

  logic [NUM_CH-1:0] s1, s2, s3, hit, rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= discIn; s2 <= s1; s3 <= s2;
    end
  end

  // per-channel edge pulse with retrigger dead window
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DEAD_W-1:0] dead;
    assign hit[i] = s2[i] & ~s3[i] & (dead == '0);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             dead <= '0;
      else if (hit[i])       dead <= DEAD_W'(holdOff) + DEAD_W'(1);
      else if (dead != '0)   dead <= dead - 1'b1;
    end
  end

  for (genvar s = 0; s < N_SECT; s++) begin : g_sect
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) fastOr[s] <= 1'b0;
      else       fastOr[s] <= |hit[s*SECT_W +: SECT_W];
    end
  end

  // latency ring
  logic [NUM_CH-1:0] ring [RING_DEPTH];
  always_ff @(posedge clk) begin
    ring[ctl.wrAddr] <= hit;
    if (ctl.capture) rdQ <= ring[ctl.rdAddr];
  end

  // event queue
  logic [NUM_CH-1:0] qHits [EVQ_DEPTH];
  logic [TAG_W-1:0]  qEvt  [EVQ_DEPTH];
  logic [TAG_W-1:0]  qBx   [EVQ_DEPTH];
  logic [EVQ_AW-1:0] qWr, qRd;
  logic [EVQ_AW:0]   qCnt;

  always_ff @(posedge clk) begin
    if (ctl.push) begin
      qHits[qWr] <= rdQ;
      qEvt[qWr]  <= ctl.evtTag;
      qBx[qWr]   <= ctl.bxTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qWr <= '0; qRd <= '0; qCnt <= '0;
    end else begin
      if (ctl.push) qWr <= qWr + 1'b1;
      if (ctl.pop)  qRd <= qRd + 1'b1;
      qCnt <= qCnt + (EVQ_AW+1)'(ctl.push) - (EVQ_AW+1)'(ctl.pop);
    end
  end

  assign rdValid = (qCnt != '0);
  assign rdHits  = qHits[qRd];
  assign rdEvt   = qEvt[qRd];
  assign rdBx    = qBx[qRd];

  p_retrig_r2: assert property (@(posedge clk) disable iff (!rstN)
    hit[0] |=> !hit[0]);

  p_push_room_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> (int'(qCnt) < EVQ_DEPTH));

  p_head_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !ctl.pop) |=> (rdValid && $stable(rdEvt) && $stable(rdBx)));
endmodule

// File: rtl/trig_latency_buf.sv
module trig_latency_buf
  import tlb_pkg::*;
#(
  parameter int NUM_CH    = 128,
  parameter int SECT_W    = 16,
  parameter int EVQ_DEPTH = 16,
  parameter int HOLD_W    = 2,
  parameter int LAT_W     = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        discIn,
  input  logic [HOLD_W-1:0]        holdOff,
  input  logic [LAT_W-1:0]         latency,
  input  logic                     l1a,
  output logic [NUM_CH/SECT_W-1:0] fastOr,
  input  logic                     rdReady,
  output logic                     rdValid,
  output logic [NUM_CH-1:0]        rdHits,
  output logic [TAG_W-1:0]         rdEvt,
  output logic [TAG_W-1:0]         rdBx,
  output logic                     overflow
);
  ctl_t ctl;

  trig_latency_ctl #(.EVQ_DEPTH(EVQ_DEPTH), .LAT_W(LAT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .l1a(l1a), .latency(latency),
    .rdReady(rdReady), .rdValid(rdValid), .ctl(ctl), .overflow(overflow)
  );

  trig_latency_dp #(.NUM_CH(NUM_CH), .SECT_W(SECT_W), .EVQ_DEPTH(EVQ_DEPTH),
                    .HOLD_W(HOLD_W)) u_dp (
    .clk(clk), .rstN(rstN), .discIn(discIn), .holdOff(holdOff), .ctl(ctl),
    .fastOr(fastOr), .rdValid(rdValid), .rdHits(rdHits), .rdEvt(rdEvt),
    .rdBx(rdBx)
  );
endmodule

// File: tb/trig_latency_buf_test.sv
module trig_latency_buf_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] discIn = '0;
  logic [1:0]   holdOff = '0;
  logic [8:0]   latency = 9'd10;
  logic         l1a = 1'b0;
  logic         rdReady = 1'b0;
  logic [7:0]   fastOr;
  logic         rdValid, overflow;
  logic [127:0] rdHits;
  logic [11:0]  rdEvt, rdBx;

  trig_latency_buf uut (
    .clk(clk), .rstN(rstN), .discIn(discIn), .holdOff(holdOff),
    .latency(latency), .l1a(l1a), .fastOr(fastOr), .rdReady(rdReady),
    .rdValid(rdValid), .rdHits(rdHits), .rdEvt(rdEvt), .rdBx(rdBx),
    .overflow(overflow)
  );

  always #2 clk = ~clk;

  int nChk = 0, nFail = 0;
  string hitTag = "R3";
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [127:0] m1, m2, m3, lastHit;
  int           mDead [128];
  logic [127:0] hist [256];
  logic [127:0] qH [64];
  int           qE [64], qB [64], qAt [64];
  int           qHead = 0, qTail = 0, edgeCnt = 0, evtE = 0;
  bit           ovfE = 1'b0;

  function automatic int clampLat(logic [8:0] l);
    if (l == 0) return 1;
    if (l > 255) return 255;
    return int'(l);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      m1 = '0; m2 = '0; m3 = '0; lastHit = '0;
      for (int i = 0; i < 128; i++) mDead[i] = 0;
      qHead = 0; qTail = 0; edgeCnt = 0; evtE = 0; ovfE = 1'b0;
    end else begin
      logic [127:0] h;
      int sz;
      bit popNow;
      h = m2 & ~m3;
      for (int i = 0; i < 128; i++) if (mDead[i] != 0) h[i] = 1'b0;
      hist[edgeCnt % 256] = h;
      lastHit = h;
      sz = qTail - qHead;
      popNow = rdReady && (sz > 0) && (qAt[qHead % 64] + 2 <= edgeCnt);
      if (l1a) begin
        if (sz == 16) ovfE = 1'b1;
        else begin
          qH[qTail % 64]  = hist[(edgeCnt - clampLat(latency)) % 256];
          qE[qTail % 64]  = evtE % 4096;
          qB[qTail % 64]  = edgeCnt % 4096;
          qAt[qTail % 64] = edgeCnt;
          qTail++;
        end
        evtE++;
      end
      if (popNow) qHead++;
      for (int i = 0; i < 128; i++) begin
        if (h[i]) mDead[i] = int'(holdOff) + 1;
        else if (mDead[i] != 0) mDead[i]--;
      end
      m3 = m2; m2 = m1; m1 = discIn;
      edgeCnt++;
    end
  end

  // ---------------- output checks at falling edge ----------------
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [7:0] fo;
      bit vis;
      for (int s = 0; s < 8; s++) fo[s] = |lastHit[s*16 +: 16];
      chk(fastOr === fo, "R1", "fastOr", 128'(fastOr), 128'(fo));
      vis = (qTail > qHead) && (qAt[qHead % 64] + 2 <= edgeCnt);
      chk(rdValid === vis, "R6", "rdValid", 128'(rdValid), 128'(vis));
      if (vis && rdValid) begin
        chk(rdHits === qH[qHead % 64], hitTag, "rdHits", rdHits, qH[qHead % 64]);
        chk(rdEvt === 12'(qE[qHead % 64]), "R5", "rdEvt", 128'(rdEvt), 128'(qE[qHead % 64]));
        chk(rdBx === 12'(qB[qHead % 64]), "R5", "rdBx", 128'(rdBx), 128'(qB[qHead % 64]));
      end
      chk(overflow === ovfE, "R8", "overflow", 128'(overflow), 128'(ovfE));
    end
  end

  // ---------------- stimulus ----------------
  task automatic randCycles(int n, int l1aOdds, bit readyRand);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      discIn  = {$urandom, $urandom, $urandom, $urandom} &
                {$urandom, $urandom, $urandom, $urandom};
      l1a     = (l1aOdds > 0) ? (($urandom % l1aOdds) == 0) : 1'b0;
      rdReady = readyRand ? $urandom[0] : 1'b1;
    end
  endtask

  int pops;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(fastOr === 8'h0, "R9", "fastOr in reset", 128'(fastOr), 128'h0);
    chk(rdValid === 1'b0, "R9", "rdValid in reset", 128'(rdValid), 128'h0);
    chk(overflow === 1'b0, "R9", "overflow in reset", 128'(overflow), 128'h0);
    rstN = 1'b1;

    // directed R1/R2: single channel 17 pulse then fast re-rise within window
    holdOff = 2'd3;
    @(negedge clk); discIn = '0; discIn[17] = 1'b1;
    @(negedge clk); discIn[17] = 1'b0;
    @(negedge clk); discIn[17] = 1'b1;   // suppressed by R2 dead window
    @(negedge clk); discIn[17] = 1'b0;
    repeat (8) @(negedge clk);

    // fill ring, then random with nominal latency (R3)
    holdOff = 2'd0; latency = 9'd10; hitTag = "R3";
    randCycles(300, 0, 1'b1);
    randCycles(2000, 8, 1'b1);
    // R2 long dead window with R4 low clamp
    holdOff = 2'd3; latency = 9'd0; hitTag = "R3 (R2 holdoff, R4 clamp 0)";
    randCycles(1000, 6, 1'b1);
    // R4 high clamp
    holdOff = 2'd1; latency = 9'd300; hitTag = "R3 (R4 clamp 300)";
    randCycles(1500, 5, 1'b1);
    latency = 9'd255; hitTag = "R3 (R4 255)";
    randCycles(500, 5, 1'b1);

    // R7/R8: drain, then flood with reader stalled
    randCycles(60, 0, 1'b0);
    @(negedge clk); rdReady = 1'b0; l1a = 1'b1;
    repeat (20) @(negedge clk);
    l1a = 1'b0;
    repeat (3) @(negedge clk);
    pops = 0;
    rdReady = 1'b1;
    for (int c = 0; c < 40; c++) begin
      if (rdValid) pops++;
      @(negedge clk);
    end
    chk(pops == 16, "R7", "events held after flood", 128'(pops), 128'd16);
    chk(overflow === 1'b1, "R8", "overflow after drain", 128'(overflow), 128'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog run did not end actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule